// File: doc/BRIEF.md
# Segment Base Register Unit

This unit holds three 64-bit linear base addresses: two segment bases used for data addressing (base 0 and base 1) and a shadow base that a supervisor keeps for itself. An execution pipeline drives update requests into it and reads the three values on every cycle to form addresses. There are three kinds of request. A segment load writes a 32-bit base into base 0 or base 1 and clears all higher bits. A privileged register write loads all 64 bits of any one of the three registers. A swap exchanges base 1 and the shadow base in one step.

The register write is accepted only at privilege level 0, only to a valid target, and only when its data is in canonical form. Canonical form means that bits 63 down to VA_BITS-1 all hold the same value. The swap is accepted only while the core runs in 64-bit mode. A rejected request changes no register and produces a one-cycle fault pulse. When several requests arrive in the same cycle, only the highest-priority one is considered, and it either executes or faults.

Top module: `seg_base_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, base0_o, base1_o and shadow_o read zero and gp_fault is low.
- R2: A segment load with no write or swap request in the same cycle sets the selected register (ld_sel 0 selects base 0, 1 selects base 1) to the 32-bit ld_base in bits 31:0 and zeros in bits 63:32. The result is visible in the cycle after the strobe.
- R3: A register write at cpl 0 with canonical data loads all 64 bits of wr_data into the target (wr_sel 0 = base 0, 1 = base 1, 2 = shadow) in the next cycle, without a fault.
- R4: A register write whose data is not canonical (bits 63 down to VA_BITS-1 not all equal) leaves all three registers unchanged and pulses gp_fault in the next cycle.
- R5: A register write with a nonzero cpl leaves all three registers unchanged and pulses gp_fault in the next cycle.
- R6: A register write with wr_sel equal to 3 leaves all three registers unchanged and pulses gp_fault in the next cycle.
- R7: A swap request with mode64 high and no write request in the same cycle exchanges base 1 and the shadow base in the next cycle. Base 0 is left unchanged.
- R8: A swap request with mode64 low leaves all registers unchanged and pulses gp_fault in the next cycle.
- R9: With several strobes in one cycle, only the register write is considered if it is present; otherwise only the swap is considered. A faulting higher-priority request blocks every lower-priority request in that cycle.
- R10: In a cycle with no strobe, whatever the values of mode64 and cpl, all registers hold their values and gp_fault is low in the next cycle.
- R11: gp_fault is high for exactly one cycle per faulting request, in the cycle after that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode64 | input | 1 | High while the core runs in 64-bit mode |
| cpl | input | CPL_W | Current privilege level |
| ld_en | input | 1 | Segment load strobe |
| ld_sel | input | 1 | Segment load target: 0 = base 0, 1 = base 1 |
| ld_base | input | SEG_W | 32-bit base from the segment load |
| wr_en | input | 1 | Privileged register write strobe |
| wr_sel | input | 2 | Write target: 0 = base 0, 1 = base 1, 2 = shadow, 3 = invalid |
| wr_data | input | DW | Register write data |
| swap_en | input | 1 | Swap strobe |
| base0_o | output | DW | Base 0 |
| base1_o | output | DW | Base 1 |
| shadow_o | output | DW | Shadow base |
| gp_fault | output | 1 | One-cycle general-protection fault pulse |

## Verification
All state in this block is the three outputs themselves, so a wrong register value appears at the ports in the cycle after the update that caused it. A wrong fault decision appears in two ways. A missing fault also changes a register in that cycle. A false fault leaves a register stale, which shows as a wrong value at once and again on every later compare. The random stimulus mixes strobes, so priority errors and swaps that lose data are also caught at the next cycle's comparison.

// File: rtl/seg_base_unit.sv
module seg_base_unit #(
  parameter int DW      = 64,
  parameter int VA_BITS = 48,
  parameter int SEG_W   = 32,
  parameter int CPL_W   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode64,
  input  logic [CPL_W-1:0] cpl,
  input  logic             ld_en,
  input  logic             ld_sel,
  input  logic [SEG_W-1:0] ld_base,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [DW-1:0]    wr_data,
  input  logic             swap_en,
  output logic [DW-1:0]    base0_o,
  output logic [DW-1:0]    base1_o,
  output logic [DW-1:0]    shadow_o,
  output logic             gp_fault
);
  localparam int HI_W = DW - VA_BITS + 1;

  logic [HI_W-1:0] wr_hi;
  logic            canon, wr_ok, swap_ok, fault_d;
  logic [DW-1:0]   ld_ext;

  assign wr_hi   = wr_data[DW-1:VA_BITS-1];
  assign canon   = (&wr_hi) | ~(|wr_hi);
  assign wr_ok   = (cpl == '0) && canon && (wr_sel != 2'd3);
  assign swap_ok = mode64;
  assign ld_ext  = {{(DW-SEG_W){1'b0}}, ld_base};
  assign fault_d = wr_en ? ~wr_ok : (swap_en & ~swap_ok);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base0_o  <= '0;
      base1_o  <= '0;
      shadow_o <= '0;
      gp_fault <= 1'b0;
    end else begin
      gp_fault <= fault_d;
      if (wr_en) begin
        if (wr_ok) begin
          case (wr_sel)
            2'd0:    base0_o  <= wr_data;
            2'd1:    base1_o  <= wr_data;
            default: shadow_o <= wr_data;
          endcase
        end
      end else if (swap_en) begin
        if (swap_ok) begin
          base1_o  <= shadow_o;
          shadow_o <= base1_o;
        end
      end else if (ld_en) begin
        if (ld_sel) base1_o <= ld_ext;
        else        base0_o <= ld_ext;
      end
    end
  end
endmodule

module seg_base_unit_chk #(
  parameter int DW      = 64,
  parameter int VA_BITS = 48,
  parameter int SEG_W   = 32,
  parameter int CPL_W   = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode64,
  input logic [CPL_W-1:0] cpl,
  input logic             ld_en,
  input logic             ld_sel,
  input logic [SEG_W-1:0] ld_base,
  input logic             wr_en,
  input logic [1:0]       wr_sel,
  input logic [DW-1:0]    wr_data,
  input logic             swap_en,
  input logic [DW-1:0]    base0_o,
  input logic [DW-1:0]    base1_o,
  input logic [DW-1:0]    shadow_o,
  input logic             gp_fault
);
  logic nc_data;
  assign nc_data = !((&wr_data[DW-1:VA_BITS-1]) || !(|wr_data[DW-1:VA_BITS-1]));

  a_r2_ld_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && !wr_en && !swap_en) |=>
      ((($past(ld_sel) ? base1_o : base0_o)) == {{(DW-SEG_W){1'b0}}, $past(ld_base)}));

  a_r4_noncanon_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && nc_data) |=>
      (gp_fault && $stable(base0_o) && $stable(base1_o) && $stable(shadow_o)));

  a_r5_priv_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cpl != '0) |=>
      (gp_fault && $stable(base0_o) && $stable(base1_o) && $stable(shadow_o)));

  a_r7_swap_exchange: assert property (@(posedge clk) disable iff (!rst_n)
    (swap_en && !wr_en && mode64) |=>
      (base1_o == $past(shadow_o) && shadow_o == $past(base1_o) && $stable(base0_o) && !gp_fault));

  a_r8_swap_mode_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (swap_en && !wr_en && !mode64) |=>
      (gp_fault && $stable(base0_o) && $stable(base1_o) && $stable(shadow_o)));

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en && !wr_en && !swap_en) |=>
      (!gp_fault && $stable(base0_o) && $stable(base1_o) && $stable(shadow_o)));
endmodule

bind seg_base_unit seg_base_unit_chk #(
  .DW(DW), .VA_BITS(VA_BITS), .SEG_W(SEG_W), .CPL_W(CPL_W)
) u_chk (.*);

// File: tb/seg_base_unit_tb.sv
module seg_base_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 64;
  localparam int VA_BITS = 48;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode64 = 1'b0;
  logic [1:0]    cpl = '0;
  logic          ld_en = 1'b0, ld_sel = 1'b0;
  logic [31:0]   ld_base = '0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_sel = '0;
  logic [63:0]   wr_data = '0;
  logic          swap_en = 1'b0;
  logic [63:0]   base0_o, base1_o, shadow_o;
  logic          gp_fault;

  logic [63:0] m0 = '0, m1 = '0, mk = '0;
  logic        mgp = 1'b0;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_base_unit u_dut (
    .clk(clk), .rst_n(rst_n), .mode64(mode64), .cpl(cpl),
    .ld_en(ld_en), .ld_sel(ld_sel), .ld_base(ld_base),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .swap_en(swap_en),
    .base0_o(base0_o), .base1_o(base1_o), .shadow_o(shadow_o), .gp_fault(gp_fault)
  );

  function automatic bit is_canon(input logic [63:0] d);
    return (&d[63:VA_BITS-1]) || !(|d[63:VA_BITS-1]);
  endfunction

  function automatic string tag_of(input bit l, input bit w, input bit s,
                                   input logic [1:0] c, input logic [1:0] ws,
                                   input logic [63:0] d, input bit m);
    string t;
    if (w) t = (c != 0) ? "R5" : (ws == 2'd3) ? "R6" : !is_canon(d) ? "R4" : "R3";
    else if (s) t = m ? "R7" : "R8";
    else if (l) t = "R2";
    else t = "R10";
    if ((int'(l) + int'(w) + int'(s)) > 1) t = {"R9/", t};
    return t;
  endfunction

  task automatic cmp(input string t, input logic [63:0] a, input logic [63:0] e, input string what);
    n_cmp++;
    if (a !== e) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", t, what, a, e);
    end
  endtask

  task automatic check_all(input string t);
    cmp(t, base0_o, m0, "base0");
    cmp(t, base1_o, m1, "base1");
    cmp(t, shadow_o, mk, "shadow");
    cmp({t, "/R11"}, {63'd0, gp_fault}, {63'd0, mgp}, "gp_fault");
  endtask

  task automatic apply(input bit l, input bit lsel, input logic [31:0] lb,
                       input bit w, input logic [1:0] ws, input logic [63:0] d,
                       input bit s, input bit m, input logic [1:0] c);
    logic [63:0] tmp;
    string t;
    ld_en = l; ld_sel = lsel; ld_base = lb;
    wr_en = w; wr_sel = ws; wr_data = d;
    swap_en = s; mode64 = m; cpl = c;
    t = tag_of(l, w, s, c, ws, d, m);
    @(posedge clk);
    mgp = 1'b0;
    if (w) begin
      if (c == 0 && ws != 2'd3 && is_canon(d)) begin
        if (ws == 2'd0) m0 = d; else if (ws == 2'd1) m1 = d; else mk = d;
      end else mgp = 1'b1;
    end else if (s) begin
      if (m) begin tmp = m1; m1 = mk; mk = tmp; end
      else mgp = 1'b1;
    end else if (l) begin
      if (lsel) m1 = {32'd0, lb}; else m0 = {32'd0, lb};
    end
    @(negedge clk);
    check_all(t);
  endtask

  function automatic logic [63:0] rnd_data();
    logic [63:0] v;
    v = {$urandom, $urandom};
    if ($urandom_range(0, 3) != 0) v = {{(64-VA_BITS){v[VA_BITS-1]}}, v[VA_BITS-1:0]};
    return v;
  endfunction

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    apply(1, 0, 32'hdead_beef, 0, 0, 0, 0, 1, 0);
    apply(0, 0, 0, 1, 2'd1, 64'hffff_8000_0000_1234, 0, 1, 0);
    apply(1, 1, 32'h0000_0042, 0, 0, 0, 0, 0, 0);
    apply(0, 0, 0, 1, 2'd2, 64'h0000_7fff_ffff_fff0, 0, 1, 0);
    apply(0, 0, 0, 1, 2'd0, 64'h0000_8000_0000_0000, 0, 1, 0);
    apply(0, 0, 0, 1, 2'd0, 64'h1234_5678_9abc_def0, 0, 1, 3);
    apply(0, 0, 0, 1, 2'd3, 64'h0000_0000_0000_0001, 0, 1, 0);
    apply(0, 0, 0, 0, 0, 0, 1, 1, 0);
    apply(0, 0, 0, 0, 0, 0, 1, 0, 0);
    apply(0, 0, 0, 0, 0, 0, 0, 0, 2);
    apply(1, 0, 32'h1111_1111, 1, 2'd0, 64'h0000_0000_2222_2222, 1, 1, 0);
    apply(1, 0, 32'h3333_3333, 1, 2'd0, 64'h8000_0000_0000_0000, 1, 1, 0);
    apply(1, 1, 32'h4444_4444, 0, 0, 0, 1, 1, 0);
    apply(1, 1, 32'h5555_5555, 0, 0, 0, 1, 0, 0);
    apply(0, 0, 0, 1, 2'd1, 64'h0000_0000_0000_0007, 0, 0, 0);

    for (int i = 0; i < 2000; i++) begin
      apply($urandom_range(0, 2) == 0, $urandom_range(0, 1) == 1, $urandom,
            $urandom_range(0, 2) == 0, 2'($urandom_range(0, 3)), rnd_data(),
            $urandom_range(0, 3) == 0, $urandom_range(0, 3) != 0,
            ($urandom_range(0, 3) == 0) ? 2'($urandom_range(1, 3)) : 2'd0);
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule